// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Bypass

This block sits between a set of level-sensitive peripheral interrupt lines and a parent interrupt controller. It samples every line into a status word and holds a software-written enable word. It drives several grouped interrupt outputs. Each grouped output is a registered OR over the sources that are enabled and asserted and that belong to that output's group mask. The group masks are fixed at elaboration.

A forward mask, also fixed at elaboration, selects sources that skip the aggregation. The raw level of each such source appears on its own bit of a bypass output vector, unaffected by the enable word. That source is then removed from every group. Bit positions outside the implemented-source mask behave as absent: they read as zero and never drive any output.

Software reaches the two registers through a plain register port with a write strobe and a combinational read path. There are no set or clear aliases, so the enable word is changed by a read-modify-write of the whole word. None of the interfaces carries a data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status level.

Top module: `irq_l2_aggregator`

## Requirements
- R1: After reset the enable word reads 0, the status word reads 0 while all sources are low, and every grouped output is 0.
- R2: A write with `reg_wr_en` high and `reg_addr` = 0x0 replaces the whole enable word with `reg_wdata` restricted to implemented bits. The new value is readable from the clock edge of the write onward.
- R3: Reading offset 0x4 returns the source levels sampled at the most recent clock edge, restricted to implemented bits. This holds whatever the enable word holds.
- R4: A write to offset 0x4 or to any offset other than 0x0 leaves the enable word unchanged.
- R5: Grouped output k is 1 in the cycle after some source is high, enabled, set in group mask k, not forwarded, and implemented. It is 0 in the cycle after no source meets all five conditions.
- R6: For each source set in the forward mask, bit i of `fwd_irq` equals that source's raw level in the same cycle, independent of the enable word. That source never affects a grouped output.
- R7: Unimplemented bit positions (default mask 0xFFF, so bits 12 to 31) always read 0 in both registers and never assert any output.
- R8: Reads of any offset other than 0x0 and 0x4 return 0.
- R9: Each enable write is a full replacement with no set or clear semantics. Bits that are 0 in the new word become 0 even if they were 1 before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_irq | input | NUM_SRC | Level-sensitive source interrupt lines |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Combinational read data for `reg_addr` |
| grp_irq | output | NUM_GRP | Registered grouped interrupt outputs to the parent |
| fwd_irq | output | NUM_SRC | Raw levels of forwarded sources, 0 elsewhere |

## Verification
On every cycle, the assertions check the following:
- the enable word takes exactly the written value on a write to offset 0x0 and holds its value otherwise;
- a grouped output follows its qualifying condition with one cycle of delay, both when it rises and when it falls;
- read data never carries unimplemented bits.

Some behaviours can only be shown by the bench scenarios, which compare against an independent model:
- that the default group and forward masks route each source to the intended output;
- that forwarded sources ignore the enable word and are kept out of the groups;
- that a write to the status offset is dropped;
- that status follows the sources while everything is disabled.

// File: rtl/irq_l2_pkg.sv
package irq_l2_pkg;
  localparam int unsigned OFS_ENABLE = 0;
  localparam int unsigned OFS_STATUS = 4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_STATUS = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irq_l2_regs.sv
module irq_l2_regs
  import irq_l2_pkg::*;
#(
  parameter int unsigned        NUM_SRC   = 32,
  parameter int unsigned        ADDR_W    = 4,
  parameter logic [NUM_SRC-1:0] IMPL_MASK = 32'h0000_0FFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic [NUM_SRC-1:0] en_q
);
  logic [NUM_SRC-1:0] stat_q;
  reg_sel_e           sel;

  always_comb begin
    if (reg_addr == ADDR_W'(OFS_ENABLE))      sel = SEL_ENABLE;
    else if (reg_addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else                                      sel = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= src_irq & IMPL_MASK;
      if (reg_wr_en && sel == SEL_ENABLE) en_q <= reg_wdata & IMPL_MASK;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ENABLE: reg_rdata = en_q;
      SEL_STATUS: reg_rdata = stat_q;
      default:    reg_rdata = '0;
    endcase
  end

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_W'(OFS_ENABLE)) |=> en_q == ($past(reg_wdata) & IMPL_MASK)); // R2
  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_addr == ADDR_W'(OFS_ENABLE)) |=> $stable(en_q)); // R4
  AST_RDATA_UNIMPL: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~IMPL_MASK) == '0); // R7
endmodule

// File: rtl/irq_l2_group.sv
module irq_l2_group #(
  parameter int unsigned        NUM_SRC  = 32,
  parameter logic [NUM_SRC-1:0] EFF_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic [NUM_SRC-1:0] en_q,
  output logic               grp_q
);
  logic qual;

  assign qual = |(src_irq & en_q & EFF_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_q <= 1'b0;
    else        grp_q <= qual;
  end

  AST_GRP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> grp_q); // R5
  AST_GRP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> !grp_q); // R5
endmodule

// File: rtl/irq_l2_bypass.sv
module irq_l2_bypass #(
  parameter int unsigned        NUM_SRC = 32,
  parameter logic [NUM_SRC-1:0] FWD_EFF = '0
) (
  input  logic [NUM_SRC-1:0] src_irq,
  output logic [NUM_SRC-1:0] fwd_irq
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_mux
    if (FWD_EFF[i]) begin : g_pass
      assign fwd_irq[i] = src_irq[i];
    end else begin : g_tie
      assign fwd_irq[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_l2_aggregator.sv
module irq_l2_aggregator #(
  parameter int unsigned                NUM_SRC   = 32,
  parameter int unsigned                NUM_GRP   = 2,
  parameter int unsigned                ADDR_W    = 4,
  parameter logic [NUM_SRC-1:0]         IMPL_MASK = 32'h0000_0FFF,
  parameter logic [NUM_SRC-1:0]         FWD_MASK  = 32'h0000_0007,
  parameter logic [NUM_GRP*NUM_SRC-1:0] GRP_MASKS = {32'h0000_0140, 32'h0000_0EBF}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic [NUM_GRP-1:0] grp_irq,
  output logic [NUM_SRC-1:0] fwd_irq
);
  localparam logic [NUM_SRC-1:0] FWD_EFF = FWD_MASK & IMPL_MASK;
  localparam logic [NUM_SRC-1:0] AGG_EFF = IMPL_MASK & ~FWD_MASK;

  logic [NUM_SRC-1:0] en_q;

  irq_l2_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)) i_regs (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en_q(en_q)
  );

  for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
    irq_l2_group #(
      .NUM_SRC(NUM_SRC),
      .EFF_MASK(GRP_MASKS[k*NUM_SRC +: NUM_SRC] & AGG_EFF)
    ) i_group (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .en_q(en_q), .grp_q(grp_irq[k])
    );
  end

  irq_l2_bypass #(.NUM_SRC(NUM_SRC), .FWD_EFF(FWD_EFF)) i_bypass (
    .src_irq(src_irq), .fwd_irq(fwd_irq)
  );

  AST_FWD_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_irq & ~src_irq) == '0); // R6
  AST_GRP_IDLE_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_irq & AGG_EFF) == '0) |=> grp_irq == '0); // R7
endmodule

// File: tb/test_irq_l2_aggregator.sv
`timescale 1ns/1ps
module test_irq_l2_aggregator;
  localparam int unsigned NS = 32;
  localparam int unsigned NG = 2;
  localparam logic [NS-1:0] IMPL = 32'h0000_0FFF;
  localparam logic [NS-1:0] FWD  = 32'h0000_0007;
  localparam logic [NS-1:0] G0   = 32'h0000_0EBF;
  localparam logic [NS-1:0] G1   = 32'h0000_0140;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] src_irq = '0, reg_wdata = '0;
  logic reg_wr_en = 0;
  logic [3:0] reg_addr = '0;
  logic [NS-1:0] reg_rdata, fwd_irq;
  logic [NG-1:0] grp_irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq_l2_aggregator i_irq_l2_aggregator (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .grp_irq(grp_irq), .fwd_irq(fwd_irq)
  );

  function automatic logic [NG-1:0] exp_grp(logic [NS-1:0] s, logic [NS-1:0] e);
    logic [NS-1:0] q = s & e & IMPL & ~FWD;
    return {|(q & G1), |(q & G0)};
  endfunction

  task automatic chk(string req, logic [NS-1:0] act, logic [NS-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [NS-1:0] d);
    @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, string req, logic [NS-1:0] exp);
    reg_addr = a; #0.5; chk(req, reg_rdata, exp);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [NS-1:0] m_en, l_src, l_en, l_wd;
    logic l_wr;
    logic [3:0] l_a;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(4'h0, "R1 enable", '0);
    rd(4'h4, "R1 status", '0);
    chk("R1 grp", NS'(grp_irq), '0);

    // R3: status follows sources while disabled
    src_irq = 32'hFFFF_FFFF;
    @(negedge clk);
    rd(4'h4, "R3/R7 status", 32'h0000_0FFF);
    chk("R5 disabled grp", NS'(grp_irq), '0);
    chk("R6/R7 fwd", fwd_irq, 32'h7);
    rd(4'h8, "R8 unmapped", '0);
    rd(4'hC, "R8 unmapped", '0);

    // R2, R7: write enable, unimplemented bits dropped
    src_irq = '0;
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, "R2/R7 enable", 32'h0000_0FFF);
    // R9 full replacement
    wr(4'h0, 32'h0000_0008);
    rd(4'h0, "R9 replace", 32'h0000_0008);
    // R4 writes elsewhere ignored
    wr(4'h4, 32'h0000_0FFF);
    rd(4'h0, "R4 status write", 32'h0000_0008);
    wr(4'h8, 32'h0000_0000);
    rd(4'h0, "R4 other write", 32'h0000_0008);

    // R5 exact timing: source 3 in group 0
    src_irq = 32'h8;
    #0.5; chk("R5 not yet", NS'(grp_irq), '0);
    @(negedge clk); chk("R5 rise", NS'(grp_irq), 32'h1);
    src_irq = '0;
    #0.5; chk("R5 hold", NS'(grp_irq), 32'h1);
    @(negedge clk); chk("R5 fall", NS'(grp_irq), '0);

    // R6: forwarded source in group mask stays out, ignores enable
    wr(4'h0, 32'h0000_0007);
    src_irq = 32'h5;
    #0.5; chk("R6 fwd raw", fwd_irq, 32'h5);
    @(negedge clk); chk("R6 no grp", NS'(grp_irq), '0);
    wr(4'h0, 32'h0);
    #0.5; chk("R6 fwd disabled", fwd_irq, 32'h5);
    // R7 unimplemented source enabled attempt
    src_irq = 32'hFFFF_F000;
    wr(4'h0, 32'hFFFF_F000);
    @(negedge clk); chk("R7 grp quiet", NS'(grp_irq), '0);
    chk("R7 fwd quiet", fwd_irq, '0);

    // random phase
    m_en = '0; l_src = src_irq; l_en = m_en; l_wr = 0; l_a = '0; l_wd = '0;
    for (int it = 0; it < 3000; it++) begin
      @(negedge clk);
      chk("R5 random grp", NS'(grp_irq), NS'(exp_grp(l_src, l_en)));
      if (l_wr && l_a == 4'h0) m_en = l_wd & IMPL;
      l_src = $urandom;
      l_en = m_en;
      l_wr = ($urandom % 4) == 0;
      l_a = 4'(($urandom % 4) * 4);
      l_wd = $urandom;
      src_irq = l_src; reg_wr_en = l_wr; reg_addr = l_a; reg_wdata = l_wd;
      #0.5;
      chk("R6 random fwd", fwd_irq, l_src & FWD & IMPL);
      if (!l_wr) begin
        if (l_a == 4'h0)      chk("R2 random enable", reg_rdata, m_en);
        else if (l_a == 4'h8 || l_a == 4'hC) chk("R8 random", reg_rdata, '0);
      end
    end
    @(negedge clk);
    reg_wr_en = 0;
    chk("R5 random last", NS'(grp_irq), NS'(exp_grp(l_src, l_en)));
    rd(4'h4, "R3 random status", l_src & IMPL);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule